// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This controller keeps a chip in one of four power modes and drives the control outputs that follow from that mode. The outputs are the current mode code, a per-subsystem enable vector, a global clock-gate enable and a state-retention flag. Software asks for a mode change through a one-cycle request strobe that carries a target mode code. Two software-programmed template vectors set which subsystems run in the two full-power modes. A periodic sleep-timer event and an I/O-pin event end the low-power modes, and each wake source counts only in the modes where it is allowed.

The modes, from highest to lowest power, are run, reduced run, sleep and hibernate. Sleep ignores both templates and keeps only a fixed set of subsystems powered, given by a parameter, so that the interval timer and the calendar clock keep running. Hibernate stops every clock and asserts retention, and only a pin event ends it. A wake always returns the chip to the full-power mode it was in before it entered the low-power mode. The regulators, the retention cells and the timer counter sit outside the block, which only drives their control signals.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: Mode codes are 2'b00 run, 2'b01 reduced run, 2'b10 sleep and 2'b11 hibernate. While reset is held, mode is 2'b00, sub_en is all zero, clk_en is 1, retain is 0 and req_err is 0.
- R2: One clock edge after mode shows run, sub_en equals tmpl_run as sampled at that edge.
- R3: One clock edge after mode shows reduced run, sub_en equals tmpl_alt as sampled at that edge.
- R4: In sleep, sub_en equals the SLEEP_KEEP parameter (default 1, only bit 0 set) whatever either template holds. clk_en stays 1 and retain stays 0.
- R5: In hibernate, sub_en is all zero, clk_en is 0 and retain is 1.
- R6: From run or reduced run, a request for a different mode changes mode at the next clock edge.
- R7: In sleep, timer_wake or pin_wake returns mode at the next edge to the full-power mode that was in force before entry.
- R8: In hibernate, timer_wake is ignored and mode stays hibernate. pin_wake returns mode at the next edge to the full-power mode in force before entry.
- R9: A request made while in sleep or hibernate, or a request for the current mode, leaves mode unchanged and raises req_err for exactly the one cycle after the request edge.
- R10: If timer_wake or pin_wake is high in the same cycle as a request to enter sleep or hibernate, the entry is cancelled, mode is unchanged and req_err stays 0.
- R11: sub_en, clk_en and retain follow mode one clock edge late, so on the first cycle of a new mode they still show the previous mode's values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | One-cycle mode-change request strobe |
| req_mode | input | 2 | Requested mode code |
| tmpl_run | input | N_SUB | Subsystem enables for run mode |
| tmpl_alt | input | N_SUB | Subsystem enables for reduced-run mode |
| timer_wake | input | 1 | Periodic sleep-timer wake event |
| pin_wake | input | 1 | I/O-pin wake event |
| mode | output | 2 | Current mode code |
| sub_en | output | N_SUB | Per-subsystem enable vector |
| clk_en | output | 1 | Clock-gate enable, low only in hibernate |
| retain | output | 1 | State-retention flag, high only in hibernate |
| req_err | output | 1 | One-cycle pulse for an ignored request |

## Verification
Mode moves one edge after the request or wake is sampled. req_err also rises one edge after the offending request and falls on the edge after that. sub_en, clk_en and retain trail mode by a further edge, so they settle two edges after the stimulus. The bench drives every input on a falling edge and samples on later falling edges: mode and req_err after one rising edge, and the enable outputs after two. It also reads the enables once after a single edge, to confirm that they still hold the previous mode's values at that point.

// File: rtl/pwr_mode_pkg.sv
// Shared mode type and helper for the power-mode controller.
// Assumes a two-bit mode code whose upper bit marks the low-power modes.
package pwr_mode_pkg;

    typedef enum logic [1:0] {
        MODE_RUN = 2'b00,
        MODE_ALT = 2'b01,
        MODE_SLP = 2'b10,
        MODE_HIB = 2'b11
    } pmode_t;

    // True for sleep and hibernate.
    function automatic logic is_low_power(pmode_t m);
        return m[1];
    endfunction

endpackage

// File: rtl/pwr_wake_qual.sv
// Wake-source qualifier: decides whether a wake event may end the current mode.
// Assumes the wake inputs are already synchronous to clk.
module pwr_wake_qual
    import pwr_mode_pkg::*;
(
    input  pmode_t mode_cur,
    input  logic   timer_wake,
    input  logic   pin_wake,
    output logic   wake_exit,
    output logic   wake_any
);

    // Per-mode wake qualification: sleep takes either source, hibernate takes pins only.
    always_comb begin
        wake_any = timer_wake | pin_wake;
        unique case (mode_cur)
            MODE_SLP: wake_exit = timer_wake | pin_wake;
            MODE_HIB: wake_exit = pin_wake;
            default:  wake_exit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pwr_mode_fsm.sv
// Mode sequencer: holds the current mode and the full-power mode to return to,
// applies the legal transition set and flags ignored requests.
// Assumes req_valid is a single-cycle strobe and the wake flags come from pwr_wake_qual.
module pwr_mode_fsm
    import pwr_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  pmode_t req_mode,
    input  logic   wake_exit,
    input  logic   wake_any,
    output pmode_t mode_q,
    output logic   err_q
);

    pmode_t ret_q;
    pmode_t mode_d;
    pmode_t ret_d;
    logic   err_d;

    // Next-state decision covering wakes, legal entries and rejected requests.
    always_comb begin
        mode_d = mode_q;
        ret_d  = ret_q;
        err_d  = 1'b0;
        if (is_low_power(mode_q)) begin
            if (wake_exit) begin
                mode_d = ret_q;
            end
            if (req_valid) begin
                err_d = 1'b1;
            end
        end else if (req_valid) begin
            if (req_mode == mode_q) begin
                err_d = 1'b1;
            end else if (is_low_power(req_mode)) begin
                if (!wake_any) begin
                    mode_d = req_mode;
                    ret_d  = mode_q;
                end
            end else begin
                mode_d = req_mode;
            end
        end
    end

    // State registers for the mode, the return mode and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RUN;
            ret_q  <= MODE_RUN;
            err_q  <= 1'b0;
        end else begin
            mode_q <= mode_d;
            ret_q  <= ret_d;
            err_q  <= err_d;
        end
    end

endmodule

// File: rtl/pwr_en_stage.sv
// Output stage: turns the registered mode into the registered enable vector,
// clock-gate enable and retention flag, one edge behind the mode.
// Assumes the templates are static, or that a change may show one edge late.
module pwr_en_stage
    import pwr_mode_pkg::*;
#(
    parameter int unsigned       N_SUB      = 8,
    parameter logic [N_SUB-1:0]  SLEEP_KEEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pmode_t           mode_q,
    input  logic [N_SUB-1:0] tmpl_run,
    input  logic [N_SUB-1:0] tmpl_alt,
    output logic [N_SUB-1:0] sub_en_q,
    output logic             clk_en_q,
    output logic             retain_q
);

    for (genvar i = 0; i < N_SUB; i++) begin : g_bit
        logic bit_d;

        // Per-subsystem select of this bit's source for the current mode.
        always_comb begin
            unique case (mode_q)
                MODE_RUN: bit_d = tmpl_run[i];
                MODE_ALT: bit_d = tmpl_alt[i];
                MODE_SLP: bit_d = SLEEP_KEEP[i];
                default:  bit_d = 1'b0;
            endcase
        end

        // Registered enable bit, cleared in reset.
        always_ff @(posedge clk) begin
            if (!rst_n) sub_en_q[i] <= 1'b0;
            else        sub_en_q[i] <= bit_d;
        end
    end

    // Registered clock-gate and retention controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en_q <= 1'b1;
            retain_q <= 1'b0;
        end else begin
            clk_en_q <= (mode_q != MODE_HIB);
            retain_q <= (mode_q == MODE_HIB);
        end
    end

endmodule

// File: rtl/pwr_mode_ctrl.sv
// Top level of the low-power mode controller: wake qualifier, mode sequencer
// and registered enable stage. Assumes all inputs are synchronous to clk.
module pwr_mode_ctrl
    import pwr_mode_pkg::*;
#(
    parameter int unsigned       N_SUB      = 8,
    parameter logic [N_SUB-1:0]  SLEEP_KEEP = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [1:0]       req_mode,
    input  logic [N_SUB-1:0] tmpl_run,
    input  logic [N_SUB-1:0] tmpl_alt,
    input  logic             timer_wake,
    input  logic             pin_wake,
    output logic [1:0]       mode,
    output logic [N_SUB-1:0] sub_en,
    output logic             clk_en,
    output logic             retain,
    output logic             req_err
);

    pmode_t mode_q;
    logic   wake_exit;
    logic   wake_any;

    pwr_wake_qual u_wake (
        .mode_cur   (mode_q),
        .timer_wake (timer_wake),
        .pin_wake   (pin_wake),
        .wake_exit  (wake_exit),
        .wake_any   (wake_any)
    );

    pwr_mode_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mode  (pmode_t'(req_mode)),
        .wake_exit (wake_exit),
        .wake_any  (wake_any),
        .mode_q    (mode_q),
        .err_q     (req_err)
    );

    pwr_en_stage #(
        .N_SUB      (N_SUB),
        .SLEEP_KEEP (SLEEP_KEEP)
    ) u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_q   (mode_q),
        .tmpl_run (tmpl_run),
        .tmpl_alt (tmpl_alt),
        .sub_en_q (sub_en),
        .clk_en_q (clk_en),
        .retain_q (retain)
    );

    assign mode = mode_q;

endmodule

// File: rtl/pwr_mode_ctrl_chk.sv
// Property checker for pwr_mode_ctrl, attached through bind.
// Assumes synchronous active-low reset; every property is disabled during reset.
module pwr_mode_ctrl_chk #(
    parameter int unsigned       N_SUB      = 8,
    parameter logic [N_SUB-1:0]  SLEEP_KEEP = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_mode,
    input logic             timer_wake,
    input logic             pin_wake,
    input logic [1:0]       mode,
    input logic [N_SUB-1:0] sub_en,
    input logic             clk_en,
    input logic             retain,
    input logic             req_err
);

    // R5: hibernate shows all enables off, clocks gated and retention on at the next edge.
    p_hib_outputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11) |=> (sub_en == '0 && !clk_en && retain));

    // R4: sleep shows the fixed keep mask at the next edge.
    p_sleep_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10) |=> (sub_en == SLEEP_KEEP && clk_en && !retain));

    // R8: without a pin event, hibernate persists.
    p_hib_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b11 && !pin_wake) |=> (mode == 2'b11));

    // R7: any wake source ends sleep at the next edge.
    p_sleep_wake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && (timer_wake || pin_wake)) |=> (mode[1] == 1'b0));

    // R9: a request for the current mode is rejected and flagged.
    p_same_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == mode) |=> (req_err && $stable(mode)));

    // R10: a low-power entry that meets a wake event is cancelled without error.
    p_cancel_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode[1] && req_valid && req_mode[1] && (timer_wake || pin_wake))
        |=> ($stable(mode) && !req_err));

    // R6: a low-power mode is only ever entered from a full-power mode.
    p_entry_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && mode != $past(mode)) |-> !$past(mode[1]));

endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(
    .N_SUB      (N_SUB),
    .SLEEP_KEEP (SLEEP_KEEP)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .timer_wake (timer_wake),
    .pin_wake   (pin_wake),
    .mode       (mode),
    .sub_en     (sub_en),
    .clk_en     (clk_en),
    .retain     (retain),
    .req_err    (req_err)
);

// File: tb/pwr_mode_ctrl_test.sv
// Directed bench for pwr_mode_ctrl: one task per scenario, each checking its own results.
module pwr_mode_ctrl_test;

    localparam int N_SUB = 8;
    localparam logic [N_SUB-1:0] KEEP = 8'h01;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             req_valid;
    logic [1:0]       req_mode;
    logic [N_SUB-1:0] tmpl_run;
    logic [N_SUB-1:0] tmpl_alt;
    logic             timer_wake;
    logic             pin_wake;
    logic [1:0]       mode;
    logic [N_SUB-1:0] sub_en;
    logic             clk_en;
    logic             retain;
    logic             req_err;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.N_SUB(N_SUB), .SLEEP_KEEP(KEEP)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .tmpl_run(tmpl_run), .tmpl_alt(tmpl_alt), .timer_wake(timer_wake),
        .pin_wake(pin_wake), .mode(mode), .sub_en(sub_en), .clk_en(clk_en),
        .retain(retain), .req_err(req_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Issue a one-cycle request at this falling edge; returns one rising edge later.
    task automatic request(input logic [1:0] m);
        req_valid = 1'b1;
        req_mode  = m;
        step();
        req_valid = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; req_valid = 1'b0; req_mode = 2'b00;
        timer_wake = 1'b0; pin_wake = 1'b0;
        tmpl_run = 8'hF7; tmpl_alt = 8'h35;
        repeat (3) step();
        check("R1 mode in reset", mode, 2'b00);
        check("R1 sub_en in reset", sub_en, 0);
        check("R1 clk_en in reset", clk_en, 1);
        check("R1 retain in reset", retain, 0);
        check("R1 req_err in reset", req_err, 0);
        rst_n = 1'b1;
        step();
        check("R2 run template", sub_en, 8'hF7);
        tmpl_run = 8'hE3;
        step();
        check("R2 run template follows change", sub_en, 8'hE3);
    endtask

    task automatic t_reduced();
        request(2'b01);
        check("R6 run to reduced", mode, 2'b01);
        check("R11 enables still run", sub_en, 8'hE3);
        step();
        check("R3 reduced template", sub_en, 8'h35);
        tmpl_alt = 8'h0C;
        step();
        check("R3 reduced template follows change", sub_en, 8'h0C);
    endtask

    task automatic t_sleep_timer();
        request(2'b10);
        check("R6 reduced to sleep", mode, 2'b10);
        check("R11 enables still reduced", sub_en, 8'h0C);
        step();
        check("R4 sleep mask", sub_en, KEEP);
        check("R4 sleep clk_en", clk_en, 1);
        check("R4 sleep retain", retain, 0);
        tmpl_run = 8'hFF; tmpl_alt = 8'hFF;
        step();
        check("R4 sleep ignores templates", sub_en, KEEP);
        timer_wake = 1'b1;
        step();
        timer_wake = 1'b0;
        check("R7 timer wake returns reduced", mode, 2'b01);
        step();
        check("R3 reduced after wake", sub_en, 8'hFF);
        tmpl_run = 8'hE3; tmpl_alt = 8'h0C;
        request(2'b00);
        check("R6 reduced to run", mode, 2'b00);
    endtask

    task automatic t_sleep_pin();
        request(2'b10);
        check("R6 run to sleep", mode, 2'b10);
        pin_wake = 1'b1;
        step();
        pin_wake = 1'b0;
        check("R7 pin wake returns run", mode, 2'b00);
        step();
        check("R2 run after sleep", sub_en, 8'hE3);
    endtask

    task automatic t_hibernate();
        request(2'b11);
        check("R6 run to hibernate", mode, 2'b11);
        check("R11 clk_en still on", clk_en, 1);
        step();
        check("R5 hib sub_en", sub_en, 0);
        check("R5 hib clk_en", clk_en, 0);
        check("R5 hib retain", retain, 1);
        timer_wake = 1'b1;
        repeat (3) step();
        timer_wake = 1'b0;
        check("R8 timer ignored in hibernate", mode, 2'b11);
        check("R8 timer ignored, clocks still off", clk_en, 0);
        request(2'b00);
        check("R9 request in hibernate flagged", req_err, 1);
        check("R9 request in hibernate ignored", mode, 2'b11);
        step();
        check("R9 error lasts one cycle", req_err, 0);
        pin_wake = 1'b1;
        step();
        pin_wake = 1'b0;
        check("R8 pin wake returns run", mode, 2'b00);
        check("R11 retain still on", retain, 1);
        step();
        check("R8 retain released", retain, 0);
        check("R8 clk_en restored", clk_en, 1);
    endtask

    task automatic t_same_mode();
        request(2'b00);
        check("R9 same-mode request flagged", req_err, 1);
        check("R9 same-mode request ignored", mode, 2'b00);
        step();
        check("R9 same-mode error one cycle", req_err, 0);
        request(2'b10);
        request(2'b01);
        check("R9 request in sleep flagged", req_err, 1);
        check("R9 request in sleep ignored", mode, 2'b10);
        timer_wake = 1'b1;
        step();
        timer_wake = 1'b0;
        check("R7 back to run", mode, 2'b00);
    endtask

    task automatic t_cancel();
        pin_wake = 1'b1;
        request(2'b10);
        pin_wake = 1'b0;
        check("R10 sleep entry cancelled by pin", mode, 2'b00);
        check("R10 no error on cancel", req_err, 0);
        timer_wake = 1'b1;
        request(2'b11);
        timer_wake = 1'b0;
        check("R10 hib entry cancelled by timer", mode, 2'b00);
        check("R10 no error on cancel timer", req_err, 0);
        step();
        check("R10 enables unchanged", sub_en, 8'hE3);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    endtask

    initial begin
        t_reset();
        t_reduced();
        t_sleep_timer();
        t_sleep_pin();
        t_hibernate();
        t_same_mode();
        t_cancel();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule